// File: doc/BRIEF.md
# Time Base Capture Unit

This block records the value of a free-running PWM time base counter when an event occurs. One of five hardware event inputs (sync, feed-forward, current limit, fault 1, fault 2) can be chosen through a 3-bit source code, and software can request a capture at any moment through the register write port. The captured count is shown on a capture output.

The block also holds four trigger-compare registers, named C, D, E and F, for comparators outside the block. Software loads them through the write port. When the capture-to-trigger path is enabled, each capture also stores half of the captured count into one chosen trigger register, on the same clock edge as the capture. The counter and the comparators are outside this block.

The write port accepts a write on every cycle and has no back-pressure. Every input is treated as synchronous to `clk`. Reset is synchronous and active-low.

Top module: `timebase_capture`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the control fields, the capture output and all four trigger outputs are cleared to 0.
- R2: The control register is at address 0, with cap_en in bit 0, source code in bits 3:1, half_en in bit 4 and trigger select in bits 6:5. Source codes 1..5 select sync, feed-forward, current limit, fault 1 and fault 2. The event input bit order is 0=sync, 1=feed-forward, 2=current limit, 3=fault 1, 4=fault 2. With cap_en=1, suppose the selected input is sampled low at edge k-1 and high at edge k. Then edge k+1 loads `cap_value` with the `tb_count` present at edge k+1.
- R3: Hardware events are ignored, and `cap_value` holds, in three cases: on inputs other than the selected one, when the source code is 0 (software only), and when the source code is 6 or 7 (reserved).
- R4: With cap_en=0, no hardware event changes `cap_value`, whatever the source code.
- R5: A write to address 1 with data bit 0 set loads `cap_value` with `tb_count` at that edge, whatever the values of cap_en and the source code. A write to address 1 with bit 0 clear has no effect.
- R6: An event input held high for many cycles produces exactly one capture.
- R7: With half_en=1, every capture also loads trigger register C, D, E or F (selected by trigger select 0, 1, 2 or 3) with the captured count shifted right by one bit, on the same edge. The other three trigger registers are unchanged.
- R8: With half_en=0, captures leave all trigger registers unchanged.
- R9: A hardware capture and a software capture on the same edge record a single capture of the current `tb_count`.
- R10: Writes to addresses 2, 3, 4 and 5 load trigger registers C, D, E and F with `wr_data`. A half-count store to the same register on the same edge takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_count | input | CW | Time base counter value |
| evt_sync | input | 1 | Sync event |
| evt_ffwd | input | 1 | Feed-forward event |
| evt_ilim | input | 1 | Current-limit event |
| evt_flt1 | input | 1 | Fault 1 event |
| evt_flt2 | input | 1 | Fault 2 event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CW | Register write data |
| cap_value | output | CW | Captured count |
| trig_c | output | CW | Trigger register C |
| trig_d | output | CW | Trigger register D |
| trig_e | output | CW | Trigger register E |
| trig_f | output | CW | Trigger register F |

## Verification
The bench holds an event input high across many cycles. A detector that responds to level instead of edge would recapture on every cycle. It fires a software strobe on the same edge as a hardware edge, where a design that adds the two or drops one would record a wrong or stale count. It also sends a direct trigger write into the register that the half-count store targets on that edge, which exposes a reversed priority. Reserved source codes and cap_en=0 are driven with live events, to catch a decoder that lets them through. Every trigger select value is used with odd counts, which exposes a shift done as rounding or in the wrong direction.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  localparam int unsigned NUM_EVT  = 5;
  localparam int unsigned NUM_TRIG = 4;
  localparam int unsigned ADDR_W   = 3;

  typedef enum logic [2:0] {
    SRC_SW_ONLY = 3'd0,
    SRC_SYNC    = 3'd1,
    SRC_FFWD    = 3'd2,
    SRC_ILIM    = 3'd3,
    SRC_FLT1    = 3'd4,
    SRC_FLT2    = 3'd5,
    SRC_RSV6    = 3'd6,
    SRC_RSV7    = 3'd7
  } cap_src_e;

  // bit 0 cap_en, bits 3:1 source, bit 4 half_en, bits 6:5 trigger select
  typedef struct packed {
    logic [1:0] tsel;
    logic       half_en;
    cap_src_e   src;
    logic       cap_en;
  } cap_ctl_t;

  localparam int unsigned CTL_W = $bits(cap_ctl_t);

  localparam logic [ADDR_W-1:0] ADR_CTL       = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CAP       = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_TRIG_BASE = 3'd2;
endpackage

// File: rtl/tbcap_regif.sv
module tbcap_regif
  import tbcap_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned NT = NUM_TRIG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output cap_ctl_t          ctl,
  output logic              sw_cap,
  output logic [NT-1:0]     trig_wr
);
  // control register, cleared by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en && wr_addr == ADR_CTL) begin
      ctl <= cap_ctl_t'(wr_data[CTL_W-1:0]);
    end
  end

  // software strobe: bit 0 of a write to the capture address
  assign sw_cap = wr_en && (wr_addr == ADR_CAP) && wr_data[0];

  // one write decode per trigger register
  for (genvar i = 0; i < NT; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] ADR_I = ADDR_W'(ADR_TRIG_BASE + i);
    assign trig_wr[i] = wr_en && (wr_addr == ADR_I);
  end
endmodule

// File: rtl/tbcap_evt_edge.sv
module tbcap_evt_edge
  import tbcap_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt,
  input  cap_ctl_t      ctl,
  output logic          hw_cap
);
  logic [NE-1:0] stg1, stg2, rise, pick;

  // register the inputs and keep one older copy for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= evt;
      stg2 <= stg1;
    end
  end

  assign rise = stg1 & ~stg2;

  // input i answers to source code i+1; codes 0, 6 and 7 match nothing
  for (genvar i = 0; i < NE; i++) begin : g_pick
    assign pick[i] = rise[i] && (ctl.src == cap_src_e'(i + 1));
  end

  assign hw_cap = ctl.cap_en && (|pick);
endmodule

// File: rtl/tbcap_trig_bank.sv
module tbcap_trig_bank #(
  parameter int unsigned CW = 16,
  parameter int unsigned NT = 4,
  localparam int unsigned SW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_half,
  input  logic [SW-1:0] tsel,
  input  logic [CW-1:0] cap_in,
  input  logic [NT-1:0] trig_wr,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] trig [NT]
);
  logic [CW-1:0] half_val;
  assign half_val = cap_in >> 1;

  for (genvar i = 0; i < NT; i++) begin : g_reg
    logic own;
    assign own = load_half && (tsel == SW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trig[i] <= '0;
      end else if (own) begin
        trig[i] <= half_val;   // half-count store wins over a direct write
      end else if (trig_wr[i]) begin
        trig[i] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/timebase_capture.sv
module timebase_capture
  import tbcap_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     tb_count,
  input  logic              evt_sync,
  input  logic              evt_ffwd,
  input  logic              evt_ilim,
  input  logic              evt_flt1,
  input  logic              evt_flt2,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     cap_value,
  output logic [CW-1:0]     trig_c,
  output logic [CW-1:0]     trig_d,
  output logic [CW-1:0]     trig_e,
  output logic [CW-1:0]     trig_f
);
  cap_ctl_t            ctl;
  logic                sw_cap;
  logic                hw_cap;
  logic                fire;
  logic [NUM_TRIG-1:0] trig_wr;
  logic [NUM_EVT-1:0]  evt_vec;
  logic [CW-1:0]       trig_q [NUM_TRIG];
  logic [CW-1:0]       cap_q;

  assign evt_vec = {evt_flt2, evt_flt1, evt_ilim, evt_ffwd, evt_sync};

  tbcap_regif #(.CW(CW), .NT(NUM_TRIG)) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl),
    .sw_cap  (sw_cap),
    .trig_wr (trig_wr)
  );

  tbcap_evt_edge #(.NE(NUM_EVT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_vec),
    .ctl    (ctl),
    .hw_cap (hw_cap)
  );

  // both sources load the same live count, so coincident requests merge
  assign fire = hw_cap | sw_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (fire) begin
      cap_q <= tb_count;
    end
  end

  tbcap_trig_bank #(.CW(CW), .NT(NUM_TRIG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_half (fire && ctl.half_en),
    .tsel      (ctl.tsel),
    .cap_in    (tb_count),
    .trig_wr   (trig_wr),
    .wr_val    (wr_data),
    .trig      (trig_q)
  );

  assign cap_value = cap_q;
  assign trig_c    = trig_q[0];
  assign trig_d    = trig_q[1];
  assign trig_e    = trig_q[2];
  assign trig_f    = trig_q[3];
endmodule

// File: rtl/tbcap_chk.sv
module tbcap_chk
  import tbcap_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     tb_count,
  input logic [NUM_EVT-1:0] evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CW-1:0]     wr_data,
  input cap_ctl_t          ctl,
  input logic [CW-1:0]     cap_value,
  input logic [CW-1:0]     trig_c,
  input logic [CW-1:0]     trig_d,
  input logic [CW-1:0]     trig_e,
  input logic [CW-1:0]     trig_f
);
  logic [NUM_EVT-1:0] e1, e2, rise;
  logic hw_fire, sw_fire, any_trig_wr, seen_edge;
  logic [CW-1:0] tv [NUM_TRIG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1 <= '0;
      e2 <= '0;
    end else begin
      e1 <= evt;
      e2 <= e1;
    end
  end
  assign rise = e1 & ~e2;

  always_comb begin
    hw_fire = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (ctl.cap_en && rise[i] && (3'(ctl.src) == 3'(i + 1))) hw_fire = 1'b1;
    end
  end

  assign sw_fire     = wr_en && wr_addr == 3'd1 && wr_data[0];
  assign any_trig_wr = wr_en && wr_addr >= 3'd2 && wr_addr <= 3'd5;
  assign tv[0] = trig_c;
  assign tv[1] = trig_d;
  assign tv[2] = trig_e;
  assign tv[3] = trig_f;

  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R1
  always @(negedge clk) begin
    if (!rst_n && seen_edge) begin
      reset_zero_chk: assert (cap_value == '0 && trig_c == '0 && trig_d == '0
                              && trig_e == '0 && trig_f == '0);
    end
  end

  // R2
  hw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire |=> cap_value == $past(tb_count));

  // R5
  sw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> cap_value == $past(tb_count));

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_fire && !sw_fire) |=> $stable(cap_value));

  // R7
  half_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_fire || sw_fire) && ctl.half_en) |=> tv[$past(ctl.tsel)] == ($past(tb_count) >> 1));

  // R8
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!((hw_fire || sw_fire) && ctl.half_en) && !any_trig_wr)
      |=> ($stable(trig_c) && $stable(trig_d) && $stable(trig_e) && $stable(trig_f)));
endmodule

bind timebase_capture tbcap_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_count  (tb_count),
  .evt       ({evt_flt2, evt_flt1, evt_ilim, evt_ffwd, evt_sync}),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ctl       (ctl),
  .cap_value (cap_value),
  .trig_c    (trig_c),
  .trig_d    (trig_d),
  .trig_e    (trig_e),
  .trig_f    (trig_f)
);

// File: tb/timebase_capture_test.sv
`timescale 1ns/1ps
module timebase_capture_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] tb_count = '0;
  logic [4:0] ev = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] cap_value, trig_c, trig_d, trig_e, trig_f;

  always #2.5 clk = ~clk;

  timebase_capture #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count),
    .evt_sync(ev[0]), .evt_ffwd(ev[1]), .evt_ilim(ev[2]),
    .evt_flt1(ev[3]), .evt_flt2(ev[4]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_value(cap_value), .trig_c(trig_c), .trig_d(trig_d),
    .trig_e(trig_e), .trig_f(trig_f)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [6:0]    m_ctl = '0;
  logic [CW-1:0] m_cap = '0;
  logic [CW-1:0] m_trig [4] = '{default: '0};
  logic [4:0]    m_e1 = '0, m_e2 = '0;
  logic [CW-1:0] cnt = 16'h0101;

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic hw_hit(input logic [6:0] c, input logic [4:0] r);
    logic [2:0] s = c[3:1];
    if (!c[0] || s == 3'd0 || s > 3'd5) return 1'b0;
    return r[s - 3'd1];
  endfunction

  task automatic step(input logic [4:0] e, input logic we, input logic [2:0] a,
                      input logic [CW-1:0] d, input string ctag);
    logic hw, sw, fire, half, dwr;
    logic [1:0] hidx, didx;
    string ct, tt;
    @(negedge clk);
    ev = e; wr_en = we; wr_addr = a; wr_data = d; tb_count = cnt;
    @(posedge clk);
    hw = hw_hit(m_ctl, m_e1 & ~m_e2);
    sw = we && a == 3'd1 && d[0];
    fire = hw || sw;
    half = fire && m_ctl[4];
    hidx = m_ctl[6:5];
    dwr = we && a >= 3'd2 && a <= 3'd5;
    didx = 2'(a - 3'd2);
    if (fire) m_cap = cnt;
    if (dwr && !(half && hidx == didx)) m_trig[didx] = d;
    if (half) m_trig[hidx] = cnt >> 1;
    if (we && a == 3'd0) m_ctl = d[6:0];
    m_e2 = m_e1;
    m_e1 = e;
    ct = (hw && sw) ? "R9" : sw ? "R5" : hw ? "R2" : (ctag != "") ? ctag : "R3";
    tt = (half && dwr && hidx == didx) ? "R10" : half ? "R7" : dwr ? "R10" : "R8";
    #1;
    chk(ct, cap_value, m_cap);
    chk(tt, trig_c, m_trig[0]);
    chk(tt, trig_d, m_trig[1]);
    chk(tt, trig_e, m_trig[2]);
    chk(tt, trig_f, m_trig[3]);
    cnt = cnt + CW'($urandom_range(1, 3));
  endtask

  task automatic idle(input logic [4:0] e, input int n, input string ctag);
    for (int i = 0; i < n; i++) step(e, 1'b0, 3'd0, '0, ctag);
  endtask

  task automatic set_ctl(input logic en, input logic [2:0] src, input logic half,
                         input logic [1:0] ts);
    step(m_e1, 1'b1, 3'd0, CW'({ts, half, src, en}), "");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R1: reset state
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'hFFFF; ev = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", cap_value, '0);
    chk("R1", trig_c, '0);
    chk("R1", trig_d, '0);
    chk("R1", trig_e, '0);
    chk("R1", trig_f, '0);
    @(negedge clk);
    rst_n = 1'b1; wr_en = 1'b0; ev = '0;
    idle('0, 2, "R1");

    // R5: software capture with everything disabled, and a no-op write
    step('0, 1'b1, 3'd1, 16'h0001, "R5");
    step('0, 1'b1, 3'd1, 16'hFFFE, "R5");
    idle('0, 1, "R5");

    // R2 and R6: sync selected, one pulse then a long high level
    set_ctl(1'b1, 3'd1, 1'b0, 2'd0);
    step(5'h01, 1'b0, 3'd0, '0, "R2");
    idle(5'h01, 12, "R6");
    idle('0, 2, "R6");

    // R2: each hardware source code 1..5 on its own input
    for (int s = 1; s <= 5; s++) begin
      set_ctl(1'b1, 3'(s), 1'b0, 2'd0);
      step(5'(1 << (s - 1)), 1'b0, 3'd0, '0, "R2");
      idle('0, 3, "R2");
    end

    // R4: enable clear with a selected edge
    set_ctl(1'b0, 3'd3, 1'b0, 2'd0);
    step(5'h04, 1'b0, 3'd0, '0, "R4");
    idle('0, 3, "R4");

    // R3: unselected input, software-only code, reserved codes
    set_ctl(1'b1, 3'd2, 1'b0, 2'd0);
    step(5'h1D, 1'b0, 3'd0, '0, "R3");
    idle('0, 3, "R3");
    for (int s = 0; s < 8; s += 6) begin
      set_ctl(1'b1, 3'(s), 1'b0, 2'd0);
      step(5'h1F, 1'b0, 3'd0, '0, "R3");
      idle('0, 3, "R3");
    end
    set_ctl(1'b1, 3'd7, 1'b0, 2'd0);
    step(5'h1F, 1'b0, 3'd0, '0, "R3");
    idle('0, 3, "R3");

    // R7: half store into each trigger register, odd counts
    for (int t = 0; t < 4; t++) begin
      set_ctl(1'b1, 3'd4, 1'b1, 2'(t));
      cnt = cnt | 16'h0001;
      step('0, 1'b1, 3'd1, 16'h0001, "R7");
      step(5'h08, 1'b0, 3'd0, '0, "R7");
      cnt = 16'hFFFF;
      idle('0, 2, "R7");
    end

    // R9: hardware edge and software strobe on the same edge
    set_ctl(1'b1, 3'd5, 1'b1, 2'd1);
    step(5'h10, 1'b0, 3'd0, '0, "R9");
    step(5'h10, 1'b1, 3'd1, 16'h0001, "R9");
    idle('0, 2, "R9");

    // R10: direct writes, then a collision with the half store
    step('0, 1'b1, 3'd2, 16'hA5A5, "R10");
    step('0, 1'b1, 3'd5, 16'h5A5A, "R10");
    set_ctl(1'b1, 3'd1, 1'b1, 2'd2);
    step('0, 1'b1, 3'd4, 16'h1234, "R10");
    step(5'h01, 1'b0, 3'd0, '0, "R10");
    step(5'h01, 1'b1, 3'd4, 16'hBEEF, "R10");
    idle('0, 2, "R10");

    // R8 and mixed: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] e;
      logic we;
      logic [2:0] a;
      logic [CW-1:0] d;
      e = m_e1;
      for (int b = 0; b < 5; b++) if ($urandom_range(0, 7) == 0) e[b] = ~e[b];
      we = ($urandom_range(0, 3) == 0);
      a = 3'($urandom_range(0, 7));
      d = CW'($urandom);
      if ($urandom_range(0, 99) == 0) cnt = CW'($urandom);
      step(e, we, a, d, "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule